// File: doc/BRIEF.md
# Card socket interrupt event controller

This block watches the status pins of one removable-card socket and turns changes on them into host interrupts. Three of the socket pins are shared by several signals. Their meaning depends on the card type that is present: a 16-bit memory card, a 16-bit I/O card or a 32-bit bus card. The two card-detect pins and an internal pulse that marks the end of socket power-up are read the same way for every card type.

Each status-change source has a sticky flag and its own mask bit. The unmasked flags are ORed together onto one host interrupt line. Functional card interrupts have no mask and drive a second, separate line. They are allowed through only while the socket reports that it is powered. Software reads the flags through a small register port, clears them by writing 1 to a flag bit, and reads and writes the masks there too.

All socket pins pass through a synchronizer before any edge is detected. Edges seen during the first few cycles after reset are ignored, so pins that are already high when reset ends do not raise false events.

Top module: `sock_evt_ctrl`

## Requirements
- R1: After reset every status flag reads 0, every mask bit reads 1 (masked), and both interrupt outputs are low.
- R2: With card_kind = 0 (16-bit memory), a rising or falling edge on sk_a, sk_b or sk_c sets flag bit 0, 1 or 2 respectively. The flag is readable three clock edges after the pin changes.
- R3: With card_kind = 1 (16-bit I/O) or 2 (32-bit bus), a rising edge on sk_a sets flag bit 3. A falling edge on sk_a, and any activity on sk_b or sk_c, sets no flag.
- R4: For every card type, an edge on either bit of sk_cd sets flag bit 4.
- R5: A one-cycle pulse on pwr_up_done sets flag bit 5 at the next clock edge.
- R6: Flags stay set until a write to address 0 has a 1 in the matching data bit. If a set event and a clear of the same flag happen in the same cycle, the flag stays set.
- R7: irq_status is high exactly when some flag in bits 5:0 is set and its mask bit is 0. Mask bits never stop a flag from being set.
- R8: irq_func equals the synchronized sk_c level ANDed with sock_powered, only for card_kind 1 or 2. It is low for card_kind 0 and 3. Flag read bit 6 shows the same value, and writing to bit 6 has no effect.
- R9: A write to address 1 loads the mask from data bits 5:0. A read of address 1 returns the mask in bits 5:0 and 0 in the bits above.
- R10: With card_kind = 3 (no card), activity on sk_a, sk_b and sk_c sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_kind | input | 2 | Card type: 0 memory, 1 I/O, 2 32-bit bus, 3 none |
| sk_a | input | 1 | Shared socket pin: battery detect 1 / status change |
| sk_b | input | 1 | Shared socket pin: battery detect 2 / speaker / audio |
| sk_c | input | 1 | Shared socket pin: ready / interrupt request |
| sk_cd | input | 2 | Card-detect pins |
| pwr_up_done | input | 1 | Internal pulse when socket power-up finishes |
| sock_powered | input | 1 | High while the socket is properly powered |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = flags (write 1 to clear), 1 = masks |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq_status | output | 1 | Status-change interrupt |
| irq_func | output | 1 | Functional card interrupt |

## Verification
A flag that is wrongly set or lost appears on reg_rdata at the next falling clock edge. When the flag's mask bit is 0, it also appears on irq_status in that same cycle. The bench's reference model follows pin history through the synchronizer delay, so an event that is decoded one cycle early or late, or under the wrong card type, shows as a mismatch within three edges of the pin change. A wrong gate on the functional path shows on irq_func as soon as sock_powered or card_kind changes.

// File: rtl/sock_evt_pkg.sv
package sock_evt_pkg;

    typedef enum logic [1:0] {
        CARD_MEM16 = 2'd0,
        CARD_IO16  = 2'd1,
        CARD_BUS32 = 2'd2,
        CARD_NONE  = 2'd3
    } card_kind_e;

    localparam int NUM_CHG    = 6;
    localparam int CHG_BATT1  = 0;
    localparam int CHG_BATT2  = 1;
    localparam int CHG_READY  = 2;
    localparam int CHG_STAT   = 3;
    localparam int CHG_DETECT = 4;
    localparam int CHG_PWR    = 5;
    localparam int FUNC_BIT   = 6;
    localparam int PIN_W      = 5;

    typedef struct packed {
        logic [1:0] cd;
        logic       c;
        logic       b;
        logic       a;
    } sock_pins_t;

    function automatic logic kind_has_func(card_kind_e k);
        return (k == CARD_IO16) || (k == CARD_BUS32);
    endfunction

    function automatic logic kind_is_mem(card_kind_e k);
        return k == CARD_MEM16;
    endfunction

endpackage

// File: rtl/sock_sync.sv
module sock_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg_q[0] <= '0;
                else     stg_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg_q[i] <= '0;
                else     stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sock_evt_decode.sv
module sock_evt_decode
    import sock_evt_pkg::*;
#(
    parameter int ARM_LEN = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  card_kind_e          kind,
    input  sock_pins_t          pins_s,
    input  logic                pwr_up_done,
    output logic [NUM_CHG-1:0]  set_vec,
    output logic                func_req
);
    localparam int ARM_W = $clog2(ARM_LEN + 1);

    sock_pins_t       prev_q;
    logic [ARM_W-1:0] arm_q;
    logic             armed;
    sock_pins_t       edg;
    sock_pins_t       rise;

    assign armed = (arm_q == ARM_W'(ARM_LEN));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            arm_q  <= '0;
        end else begin
            prev_q <= pins_s;
            if (!armed) arm_q <= arm_q + 1'b1;
        end
    end

    assign edg  = pins_s ^ prev_q;
    assign rise = pins_s & ~prev_q;

    always_comb begin
        set_vec             = '0;
        set_vec[CHG_BATT1]  = armed && kind_is_mem(kind) && edg.a;
        set_vec[CHG_BATT2]  = armed && kind_is_mem(kind) && edg.b;
        set_vec[CHG_READY]  = armed && kind_is_mem(kind) && edg.c;
        set_vec[CHG_STAT]   = armed && kind_has_func(kind) && rise.a;
        set_vec[CHG_DETECT] = armed && (|edg.cd);
        set_vec[CHG_PWR]    = pwr_up_done;
    end

    assign func_req = kind_has_func(kind) && pins_s.c;
endmodule

// File: rtl/sock_flag_bank.sv
module sock_flag_bank
    import sock_evt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CHG-1:0] set_vec,
    input  logic [NUM_CHG-1:0] clr_vec,
    input  logic               mask_wr,
    input  logic [NUM_CHG-1:0] mask_wdata,
    output logic [NUM_CHG-1:0] flags,
    output logic [NUM_CHG-1:0] mask
);
    for (genvar i = 0; i < NUM_CHG; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
                mask[i]  <= 1'b1;
            end else begin
                if (set_vec[i])      flags[i] <= 1'b1;
                else if (clr_vec[i]) flags[i] <= 1'b0;
                if (mask_wr)         mask[i]  <= mask_wdata[i];
            end
        end
    end
endmodule

// File: rtl/sock_evt_ctrl.sv
module sock_evt_ctrl
    import sock_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       card_kind,
    input  logic             sk_a,
    input  logic             sk_b,
    input  logic             sk_c,
    input  logic [1:0]       sk_cd,
    input  logic             pwr_up_done,
    input  logic             sock_powered,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_status,
    output logic             irq_func
);
    localparam int ARM_LEN = SYNC_STAGES + 1;

    card_kind_e          kind;
    sock_pins_t          pins_raw;
    sock_pins_t          pins_s;
    logic [NUM_CHG-1:0]  set_vec;
    logic [NUM_CHG-1:0]  clr_vec;
    logic [NUM_CHG-1:0]  flag_q;
    logic [NUM_CHG-1:0]  mask_q;
    logic                func_req;
    logic                unused_wr_hi;

    assign kind     = card_kind_e'(card_kind);
    assign pins_raw = '{cd: sk_cd, c: sk_c, b: sk_b, a: sk_a};

    sock_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    sock_evt_decode #(.ARM_LEN(ARM_LEN)) u_decode (
        .clk         (clk),
        .rst         (rst),
        .kind        (kind),
        .pins_s      (pins_s),
        .pwr_up_done (pwr_up_done),
        .set_vec     (set_vec),
        .func_req    (func_req)
    );

    assign clr_vec = (reg_wr && !reg_addr) ? reg_wdata[NUM_CHG-1:0] : '0;

    sock_flag_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec),
        .mask_wr    (reg_wr && reg_addr),
        .mask_wdata (reg_wdata[NUM_CHG-1:0]),
        .flags      (flag_q),
        .mask       (mask_q)
    );

    assign unused_wr_hi = ^reg_wdata[REG_W-1:NUM_CHG];

    assign irq_status = |(flag_q & ~mask_q);
    assign irq_func   = func_req && sock_powered;

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr) begin
            reg_rdata[NUM_CHG-1:0] = flag_q;
            reg_rdata[FUNC_BIT]    = irq_func;
        end else begin
            reg_rdata[NUM_CHG-1:0] = mask_q;
        end
    end
endmodule

// File: rtl/sock_evt_checker.sv
module sock_evt_checker
    import sock_evt_pkg::*;
#(
    parameter int REG_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         card_kind,
    input logic               sock_powered,
    input logic               pwr_up_done,
    input logic               reg_wr,
    input logic               reg_addr,
    input logic [REG_W-1:0]   reg_wdata,
    input logic [NUM_CHG-1:0] flags,
    input logic [NUM_CHG-1:0] mask,
    input logic [NUM_CHG-1:0] set_vec,
    input logic               irq_func
);
    logic [NUM_CHG-1:0] clr_req;
    logic [NUM_CHG-1:0] keep;
    assign clr_req = (reg_wr && !reg_addr) ? reg_wdata[NUM_CHG-1:0] : '0;
    assign keep    = flags & ~clr_req;

    // R5: power-done pulse lands in its flag one edge later
    assert_pwr_flag_R5: assert property (@(posedge clk) disable iff (rst)
        pwr_up_done |=> flags[CHG_PWR]);

    // R6: flags not cleared stay set
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(keep)) == $past(keep)));

    // R6: a set event always wins, even against a clear
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R9: a mask write is reflected on the next edge
    assert_mask_load_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr) |=> (mask == $past(reg_wdata[NUM_CHG-1:0])));

    // R8: no functional interrupt from an unpowered socket
    assert_func_power_R8: assert property (@(posedge clk) disable iff (rst)
        !sock_powered |-> !irq_func);

    // R8: memory and empty sockets never raise a functional interrupt
    assert_func_kind_R8: assert property (@(posedge clk) disable iff (rst)
        (card_kind == 2'd0 || card_kind == 2'd3) |-> !irq_func);
endmodule

bind sock_evt_ctrl sock_evt_checker #(.REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .card_kind    (card_kind),
    .sock_powered (sock_powered),
    .pwr_up_done  (pwr_up_done),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .flags        (flag_q),
    .mask         (mask_q),
    .set_vec      (set_vec),
    .irq_func     (irq_func)
);

// File: tb/sock_evt_ctrl_bench.sv
module sock_evt_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] card_kind;
    logic       sk_a, sk_b, sk_c;
    logic [1:0] sk_cd;
    logic       pwr_up_done, sock_powered;
    logic       reg_wr, reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq_status, irq_func;

    always #5 clk = ~clk;

    sock_evt_ctrl u_sock_evt_ctrl (
        .clk(clk), .rst(rst), .card_kind(card_kind),
        .sk_a(sk_a), .sk_b(sk_b), .sk_c(sk_c), .sk_cd(sk_cd),
        .pwr_up_done(pwr_up_done), .sock_powered(sock_powered),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_status(irq_status), .irq_func(irq_func)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // Reference model: pin history {cd[1:0], c, b, a}, flags, masks
    logic [4:0] hist [$];
    logic [5:0] m_flags = '0;
    logic [5:0] m_mask  = 6'h3F;

    always @(posedge clk) begin
        logic [4:0] s_v, p_v, ed, ri;
        logic [5:0] setv, clrv;
        hist.push_front({sk_cd, sk_c, sk_b, sk_a});
        if (hist.size() > 6) void'(hist.pop_back());
        if (rst) begin
            hist    = '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0};
            m_flags = '0;
            m_mask  = 6'h3F;
        end else begin
            s_v  = hist[2];
            p_v  = hist[3];
            ed   = s_v ^ p_v;
            ri   = s_v & ~p_v;
            setv = '0;
            if (card_kind == 2'd0) setv[2:0] = ed[2:0];
            if (card_kind == 2'd1 || card_kind == 2'd2) setv[3] = ri[0];
            setv[4] = ed[3] | ed[4];
            setv[5] = pwr_up_done;
            clrv = (reg_wr && !reg_addr) ? reg_wdata[5:0] : 6'd0;
            m_flags = (m_flags & ~clrv) | setv;
            if (reg_wr && reg_addr) m_mask = reg_wdata[5:0];
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every cycle
    always @(negedge clk) begin
        logic       e_func, e_stat;
        logic [7:0] e_rd;
        if (!rst && !done && hist.size() > 2) begin
            e_func = (card_kind == 2'd1 || card_kind == 2'd2) && hist[1][2] && sock_powered;
            e_stat = |(m_flags & ~m_mask);
            e_rd   = reg_addr ? {2'b00, m_mask} : {1'b0, e_func, m_flags};
            chk({cur_req, " irq_status (R7)"}, {7'd0, irq_status}, {7'd0, e_stat});
            chk({cur_req, " irq_func (R8)"}, {7'd0, irq_func}, {7'd0, e_func});
            chk({cur_req, " reg_rdata"}, reg_rdata, e_rd);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    endtask

    task automatic peek(string req, logic a, logic [7:0] exp);
        reg_addr = a;
        @(negedge clk);
        chk(req, reg_rdata, exp);
        tick();
        reg_addr = 1'b0;
    endtask

    task automatic settle();
        repeat (4) tick();
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; card_kind = 2'd0; sk_a = 0; sk_b = 0; sk_c = 0; sk_cd = 2'b00;
        pwr_up_done = 0; sock_powered = 0; reg_wr = 0; reg_addr = 0; reg_wdata = '0;
        repeat (3) tick();
        rst = 1'b0;
        repeat (5) tick();

        cur_req = "R1";
        peek("R1 flags after reset", 1'b0, 8'h00);
        peek("R1 masks after reset", 1'b1, 8'h3F);
        @(negedge clk);
        chk("R1 irq outputs after reset", {6'd0, irq_status, irq_func}, 8'h00);
        tick();

        cur_req = "R9";
        wr(1'b1, 8'hFF);
        peek("R9 mask upper bits read 0", 1'b1, 8'h3F);
        wr(1'b1, 8'h00);
        peek("R9 mask cleared", 1'b1, 8'h00);

        cur_req = "R2";
        sk_a = 1; settle();
        peek("R2 rise on pin a, memory", 1'b0, 8'h01);
        wr(1'b0, 8'h01);
        sk_a = 0; settle();
        peek("R2 fall on pin a, memory", 1'b0, 8'h01);
        wr(1'b0, 8'h01);
        sk_b = 1; settle();
        peek("R2 pin b, memory", 1'b0, 8'h02);
        sk_c = 1; settle();
        peek("R2 pin c, memory", 1'b0, 8'h06);
        sk_c = 0; sk_b = 0; settle();
        wr(1'b0, 8'h3F);
        peek("R6 write-1 clears all", 1'b0, 8'h00);

        cur_req = "R5";
        pwr_up_done = 1; tick(); pwr_up_done = 0;
        peek("R5 power-done flag", 1'b0, 8'h20);

        cur_req = "R6";
        pwr_up_done = 1; wr(1'b0, 8'h20); pwr_up_done = 0;
        peek("R6 set beats clear", 1'b0, 8'h20);
        wr(1'b0, 8'h20);
        peek("R6 clear alone", 1'b0, 8'h00);

        cur_req = "R7";
        wr(1'b1, 8'h20);
        pwr_up_done = 1; tick(); pwr_up_done = 0;
        @(negedge clk);
        chk("R7 masked flag keeps irq_status low", {7'd0, irq_status}, 8'h00);
        tick();
        peek("R7 masked flag still set", 1'b0, 8'h20);
        wr(1'b1, 8'h00);
        @(negedge clk);
        chk("R7 unmasked flag raises irq_status", {7'd0, irq_status}, 8'h01);
        tick();
        wr(1'b0, 8'h3F);

        cur_req = "R3";
        card_kind = 2'd1; tick();
        sk_a = 1; settle();
        peek("R3 rise on status pin, I/O", 1'b0, 8'h08);
        wr(1'b0, 8'h08);
        sk_a = 0; settle();
        sk_b = 1; settle(); sk_b = 0; settle();
        peek("R3 fall and pin b ignored", 1'b0, 8'h00);

        cur_req = "R4";
        card_kind = 2'd2; tick();
        sk_cd = 2'b01; settle();
        peek("R4 detect edge, bus card", 1'b0, 8'h10);
        wr(1'b0, 8'h10);
        sk_cd = 2'b11; settle();
        peek("R4 second detect edge", 1'b0, 8'h10);
        wr(1'b0, 8'h10);

        cur_req = "R8";
        sk_c = 1; settle();
        peek("R8 unpowered socket gates request", 1'b0, 8'h00);
        sock_powered = 1;
        peek("R8 powered bus request in bit 6", 1'b0, 8'h40);
        wr(1'b0, 8'h40);
        peek("R8 write to bit 6 ignored", 1'b0, 8'h40);
        card_kind = 2'd1; tick();
        @(negedge clk);
        chk("R8 I/O request passes", {7'd0, irq_func}, 8'h01);
        tick();
        card_kind = 2'd0; tick();
        @(negedge clk);
        chk("R8 memory card has no functional irq", {7'd0, irq_func}, 8'h00);
        tick();
        sk_c = 0; settle();
        wr(1'b0, 8'h3F);

        cur_req = "R10";
        card_kind = 2'd3; tick();
        sk_a = 1; sk_b = 1; sk_c = 1; settle();
        sk_a = 0; sk_b = 0; sk_c = 0; settle();
        peek("R10 empty socket ignores shared pins", 1'b0, 8'h00);

        repeat (3) tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule